// File: doc/BRIEF.md
# System control register bank

A bank of 32-bit control and status words reached through a single-cycle, word-indexed register port with separate read and write strobes. The byte address drops its two low bits to pick a word. Most words are plain read/write storage that clears at reset. A few words have their own rules. One word is a read-only lock status. A second status word holds a fixed pattern after reset. Three words are memory-remap controls whose contents never change. One word is a fabric clock configuration word whose reset value is built from two bus clock divisor parameters.

Each divisor is turned into a 3-bit divider code. The code is the number of trailing zeros of the divisor. For divisors of 8 or more, one is added to that count. Divisor legality is checked when the design is elaborated, not by logic.

Read data is registered and comes back one cycle after the read strobe. Accesses outside the bank and attempts to change a remap word each raise a one-cycle indication. Neither has any other effect.

Top module: `sysctl_regbank`

## Requirements
- R1: The word index is the byte address shifted right by two. The two low address bits have no effect on which word is read or written.
- R2: A read strobe in cycle n makes rvalid high in cycle n+1, with rdata holding the addressed word's value from before any write in cycle n. rvalid is low in every cycle that does not follow a read strobe.
- R3: A read whose word index is NUM_WORDS or more returns rdata 0 and raises bad_access for one cycle.
- R4: A write whose word index is NUM_WORDS or more changes no word (no aliasing onto a lower index) and raises bad_access for one cycle.
- R5: After reset, the lock status word (default index 9) reads 0x00000003 and the status pattern word (default index 8) reads 0x021A2358. Ordinary words and remap words read 0.
- R6: Writes to the lock status word leave its value unchanged.
- R7: Writes to the three remap words (default indices 0, 1, 2) leave their values unchanged. Such a write raises unsupported for one cycle only when the write data differs from the stored value.
- R8: The clock configuration word (default index 4) resets with the first divisor's code in bits [7:5], the second divisor's code in bits [4:2], and all other bits zero. The code maps divisors 1, 2, 4, 8, 16, 32 to 0, 1, 2, 4, 5, 6. The default divisors of 2 and 2 give 0x00000024; divisors of 32 and 8 give 0x000000D0.
- R9: Ordinary words, including the clock configuration word, store all 32 bits of any in-range write.
- R10: A divisor that is not a power of two in the range 1 to 32 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | rdata valid, one cycle after rd_en |
| bad_access | output | 1 | One-cycle pulse for an out-of-range access |
| unsupported | output | 1 | One-cycle pulse for a remap write with differing data |

## Verification
The divisor-to-code mapping is tried with two divisor pairs. The default pair (2, 2) gives equal codes. The pair (32, 8) gives two different codes, both in the shifted range at 8 and above, so a missing +1 or swapped fields shows up. Writes are tried against each register class (plain, lock status, remap, clock configuration) with data that differs from the reset value, which separates stored words from locked words. A remap write with equal data and one with differing data tell a correct unsupported pulse from one tied to every write. Out-of-range writes use an index whose low bits alias the clock configuration word, so any wrap-around corrupts a known value. A read with nonzero low address bits shows whether those bits reach the decoder.

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int ADDR_W      = 8,
  parameter int NUM_WORDS   = 16,
  parameter int BUS0_DIV    = 2,
  parameter int BUS1_DIV    = 2,
  parameter int IDX_REMAP0  = 0,
  parameter int IDX_REMAP1  = 1,
  parameter int IDX_REMAP2  = 2,
  parameter int IDX_CLKCFG  = 4,
  parameter int IDX_PLL_LO  = 8,
  parameter int IDX_PLL_ST  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic              bad_access,
  output logic              unsupported
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int SEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  function automatic bit div_ok(int d);
    bit ok = 1'b0;
    for (int b = 0; b <= 5; b++) if (d == (1 << b)) ok = 1'b1;
    return ok;
  endfunction

  function automatic logic [2:0] div_code(int d);
    int tz = 0;
    for (int b = 0; b <= 5; b++) if (d == (1 << b)) tz = b;
    return (d >= 8) ? 3'(tz + 1) : 3'(tz);
  endfunction

  localparam logic [31:0] CLKCFG_RST = {24'h0, div_code(BUS0_DIV), div_code(BUS1_DIV), 2'b00};

  function automatic logic [31:0] reset_word(int i);
    if (i == IDX_PLL_LO) return 32'h021A_2358;
    if (i == IDX_PLL_ST) return 32'h0000_0003;
    if (i == IDX_CLKCFG) return CLKCFG_RST;
    return 32'h0;
  endfunction

  // R10: elaboration-time divisor legality
  initial begin
    assert_div_legal_R10: assert (div_ok(BUS0_DIV) && div_ok(BUS1_DIV))
      else $fatal(1, "bus divisor must be a power of two from 1 to 32");
  end

  logic [31:0]      mem [NUM_WORDS];
  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] sel;
  logic             in_range, is_remap, is_locked;

  assign idx       = addr[ADDR_W-1:2];
  assign sel       = idx[SEL_W-1:0];
  assign in_range  = int'(idx) < NUM_WORDS;
  assign is_remap  = (int'(sel) == IDX_REMAP0) || (int'(sel) == IDX_REMAP1) ||
                     (int'(sel) == IDX_REMAP2);
  assign is_locked = is_remap || (int'(sel) == IDX_PLL_ST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= reset_word(i);
    end else if (wr_en && in_range && !is_locked) begin
      mem[sel] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata       <= '0;
      rvalid      <= 1'b0;
      bad_access  <= 1'b0;
      unsupported <= 1'b0;
    end else begin
      rvalid      <= rd_en;
      if (rd_en) rdata <= in_range ? mem[sel] : 32'h0;
      bad_access  <= (rd_en || wr_en) && !in_range;
      unsupported <= wr_en && in_range && is_remap && (wdata != mem[sel]);
    end
  end

  assert_rvalid_follows_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  assert_no_rvalid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  assert_bad_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_range) |=> (rdata == 32'h0) && bad_access);
  assert_bad_write_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range) |=> bad_access);
  assert_pll_status_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mem[IDX_PLL_ST]));
  assert_remap_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mem[IDX_REMAP0]) && $stable(mem[IDX_REMAP1]) && $stable(mem[IDX_REMAP2]));
  assert_unsup_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> $past(wr_en));

endmodule

// File: tb/sysctl_regbank_tb_top.sv
module sysctl_regbank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata2;
  logic        rvalid, bad_access, unsupported;
  logic        rvalid2, bad2, unsup2;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .rvalid(rvalid), .bad_access(bad_access),
    .unsupported(unsupported));

  sysctl_regbank #(.BUS0_DIV(32), .BUS1_DIV(8)) dut2_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata2), .rvalid(rvalid2), .bad_access(bad2),
    .unsupported(unsup2));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d,
                         output logic v, output logic bad);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata; v = rvalid; bad = bad_access;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d,
                          output logic bad, output logic uns);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    bad = bad_access; uns = unsupported;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic v, b;
    check("R2 idle rvalid", 32'(rvalid), 32'h0);
    do_read(8'd9 << 2, d, v, b);
    check("R5 lock status", d, 32'h3);
    check("R2 rvalid", 32'(v), 32'h1);
    do_read(8'd8 << 2, d, v, b);
    check("R5 status pattern", d, 32'h021A2358);
    do_read(8'd3 << 2, d, v, b);
    check("R5 plain zero", d, 32'h0);
    do_read(8'd1 << 2, d, v, b);
    check("R5 remap zero", d, 32'h0);
    do_read(8'd4 << 2, d, v, b);
    check("R8 clkcfg default", d, 32'h24);
    check("R8 clkcfg 32/8", rdata2, 32'hD0);
    @(negedge clk);
    check("R2 rvalid drops", 32'(rvalid), 32'h0);
  endtask

  task automatic t_plain();
    logic [31:0] d; logic v, b, u;
    do_write(8'd3 << 2, 32'hDEADBEEF, b, u);
    do_read(8'd3 << 2, d, v, b);
    check("R9 plain rw", d, 32'hDEADBEEF);
    do_read((8'd3 << 2) | 8'd3, d, v, b);
    check("R1 low addr bits", d, 32'hDEADBEEF);
    do_write((8'd15 << 2) | 8'd2, 32'h12345678, b, u);
    do_read(8'd15 << 2, d, v, b);
    check("R1 R9 last word", d, 32'h12345678);
    check("R4 no bad in range", 32'(b), 32'h0);
    do_write(8'd4 << 2, 32'hA5A5_0F0F, b, u);
    do_read(8'd4 << 2, d, v, b);
    check("R9 clkcfg writable", d, 32'hA5A5_0F0F);
  endtask

  task automatic t_pll();
    logic [31:0] d; logic v, b, u;
    do_write(8'd9 << 2, 32'hFFFF_FFFF, b, u);
    do_read(8'd9 << 2, d, v, b);
    check("R6 lock status held", d, 32'h3);
  endtask

  task automatic t_remap();
    logic [31:0] d; logic v, b, u;
    do_write(8'd1 << 2, 32'h0, b, u);
    check("R7 equal write no pulse", 32'(u), 32'h0);
    do_write(8'd1 << 2, 32'h55, b, u);
    check("R7 differing write pulse", 32'(u), 32'h1);
    @(negedge clk);
    check("R7 pulse one cycle", 32'(unsupported), 32'h0);
    do_read(8'd1 << 2, d, v, b);
    check("R7 remap held", d, 32'h0);
    do_write(8'd2 << 2, 32'h1, b, u);
    do_read(8'd2 << 2, d, v, b);
    check("R7 remap2 held", d, 32'h0);
  endtask

  task automatic t_bad();
    logic [31:0] d; logic v, b, u;
    do_write(8'd4 << 2, 32'h24, b, u);
    do_read(8'd16 << 2, d, v, b);
    check("R3 bad read data", d, 32'h0);
    check("R3 bad read flag", 32'(b), 32'h1);
    @(negedge clk);
    check("R3 flag one cycle", 32'(bad_access), 32'h0);
    do_write(8'd20 << 2, 32'hAAAA_AAAA, b, u);
    check("R4 bad write flag", 32'(b), 32'h1);
    do_read(8'd4 << 2, d, v, b);
    check("R4 no alias", d, 32'h24);
    do_read(8'd63 << 2, d, v, b);
    check("R3 top index", d, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_pll();
    t_remap();
    t_bad();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule